// File: doc/BRIEF.md
# Link Status Command Generator

This block watches the status signals of a USB transceiver and tells the link layer when they change. It follows the line state, the receive event code, and five detector outputs: B-session valid, VBUS valid, session valid, session end and ID ground. It packs the reported fields into an 8-bit status command and offers that byte to the bus side through a valid/grant handshake. Every qualifying change loads the newest status into a single command slot. If an earlier command has not yet been taken, the new status replaces it, so the link never receives stale copies and never misses the latest state.

Each detector has its own rising-edge and falling-edge enable. These enables decide whether an edge sets that detector's interrupt latch. For the VBUS valid, session valid, session end and ID detectors, the same enables decide whether the edge requests a command. A falling edge of B-session valid does not change any reported field. When its falling enable is set, it instead requests a command with the alternate-interrupt bit set. The ID detector is reported only while the ID pull-up control is on. One command carrying the present status is issued just after every reset.

Top module: `rxcmd_status_gen`

## Requirements
- R1: No command is offered while reset is active. On the first clock edge after reset is released, exactly one command is offered that carries the status present at that edge, and no interrupt latch is set by it.
- R2: Command byte layout:
  - Bits [1:0] hold the line state (00 SE0, 01 J, 10 K, 11 SE1).
  - Bits [3:2] hold the VBUS level: 11 if VBUS valid, else 10 if session valid, else 00 if session end, else 01.
  - Bits [5:4] hold the receive event code.
  - Bit 6 holds the reported ID ground value.
  - Bit 7 is the alternate-interrupt flag.
- R3: A change of line state or receive event code makes `cmd_valid` high on the next clock edge, whatever the enables are.
- R4: While `cmd_valid` is high and `cmd_grant` is low, `cmd_valid` stays high. In the same situation `cmd_byte` keeps its value unless a new change arrives. A command is consumed at an edge where both are high.
- R5: A change that arrives while a command is waiting replaces the waiting byte with the newest status. A change at the same edge as a grant leaves a fresh command offered. After one grant with no further change, `cmd_valid` is low.
- R6: Detector index map: 0 B-session valid, 1 VBUS valid, 2 session valid, 3 session end, 4 ID ground. For indices 1 to 4, an edge requests a command only if `rise_en[i]` (rising edge) or `fall_en[i]` (falling edge) is set.
- R7: While `id_pullup` is 0, a change on the ID detector requests no command and sets no latch, and bit 6 keeps its last reported value.
- R8: A falling edge of B-session valid with `fall_en[0]` set requests a command with bit 7 set. That flag stays set in any replacement byte until the command is consumed. A rising edge of B-session valid requests no command.
- R9: `irq_latch[i]` is set by an enabled edge of detector i. It is cleared by a `clr_stb` pulse with `clr_mask[i]` set. If a set and a clear fall on the same edge, the set wins.
- R10: `status_live` shows the detector inputs one clock edge after they are applied, using the index map of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| line_state | input | 2 | Line state of the transceiver |
| rx_event | input | 2 | Receive event code |
| det_in | input | 5 | Detector outputs, index map in R6 |
| id_pullup | input | 1 | ID pull-up control; enables ID reporting |
| rise_en | input | 5 | Per-detector rising-edge enables |
| fall_en | input | 5 | Per-detector falling-edge enables |
| clr_stb | input | 1 | Latch clear strobe |
| clr_mask | input | 5 | Latches cleared by the strobe |
| cmd_grant | input | 1 | Bus side accepts the offered command |
| cmd_valid | output | 1 | A command is offered |
| cmd_byte | output | 8 | Command byte, layout in R2 |
| irq_latch | output | 5 | Latched interrupt flags |
| status_live | output | 5 | Registered current detector values |

## Verification
The block has no run-time size parameters: field widths and the detector count sit in the package at their fixed values, and the bench builds it that way. All five detector lanes and all four VBUS level codes can therefore be reached from a short vector table. Directed cases then cover the corner cases:
- the alternate-interrupt flag staying set across a replacement byte;
- a grant at the same edge as a change;
- ID reporting while the pull-up is off;
- a latch set and clear on the same edge.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int LS_W   = 2;
  localparam int EVT_W  = 2;
  localparam int VB_W   = 2;
  localparam int NDET   = 5;
  localparam int BODY_W = LS_W + VB_W + EVT_W + 1;
  localparam int BYTE_W = BODY_W + 1;

  localparam int DET_BV = 0;
  localparam int DET_VV = 1;
  localparam int DET_SV = 2;
  localparam int DET_SE = 3;
  localparam int DET_ID = 4;

  localparam logic [NDET-1:0] CMD_EDGE_MASK = {NDET{1'b1}} ^ (NDET'(1) << DET_BV);
  localparam logic [NDET-1:0] ID_GATE_MASK  = {NDET{1'b1}} ^ (NDET'(1) << DET_ID);

  typedef enum logic [VB_W-1:0] {
    VB_LOW   = 2'b00,
    VB_MID   = 2'b01,
    VB_SESS  = 2'b10,
    VB_VALID = 2'b11
  } vbus_lvl_e;

  function automatic vbus_lvl_e vbus_level(input logic [NDET-1:0] d);
    if (d[DET_VV])      return VB_VALID;
    else if (d[DET_SV]) return VB_SESS;
    else if (d[DET_SE]) return VB_LOW;
    else                return VB_MID;
  endfunction

  function automatic logic [BODY_W-1:0] pack_body(
    input logic [LS_W-1:0]  ls,
    input logic [EVT_W-1:0] evt,
    input logic [NDET-1:0]  d,
    input logic             id_bit
  );
    return {id_bit, evt, vbus_level(d), ls};
  endfunction
endpackage

// File: rtl/rxg_sampler.sv
module rxg_sampler (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [rxg_pkg::LS_W-1:0]    ls,
  input  logic [rxg_pkg::EVT_W-1:0]   evt,
  input  logic [rxg_pkg::NDET-1:0]    det,
  input  logic                        id_pullup,
  output logic                        boot,
  output logic                        ls_chg,
  output logic                        evt_chg,
  output logic [rxg_pkg::NDET-1:0]    rise,
  output logic [rxg_pkg::NDET-1:0]    fall,
  output logic [rxg_pkg::BODY_W-1:0]  body_new,
  output logic [rxg_pkg::NDET-1:0]    det_live
);
  import rxg_pkg::*;

  logic [LS_W-1:0]  ls_q;
  logic [EVT_W-1:0] evt_q;
  logic [NDET-1:0]  det_q;
  logic             id_rep_q;
  logic             boot_q;
  logic [NDET-1:0]  gate;
  logic             id_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_q     <= '0;
      evt_q    <= '0;
      det_q    <= '0;
      id_rep_q <= 1'b0;
      boot_q   <= 1'b1;
    end else begin
      ls_q   <= ls;
      evt_q  <= evt;
      det_q  <= det;
      boot_q <= 1'b0;
      if (id_pullup) id_rep_q <= det[DET_ID];
    end
  end

  // the ID lane only counts while the pull-up is on
  assign gate     = id_pullup ? {NDET{1'b1}} : ID_GATE_MASK;
  assign boot     = boot_q;
  assign ls_chg   = !boot_q && (ls != ls_q);
  assign evt_chg  = !boot_q && (evt != evt_q);
  assign rise     = boot_q ? '0 : (det & ~det_q & gate);
  assign fall     = boot_q ? '0 : (~det & det_q & gate);
  assign id_now   = id_pullup ? det[DET_ID] : id_rep_q;
  assign body_new = pack_body(ls, evt, det, id_now);
  assign det_live = det_q;
endmodule

// File: rtl/rxg_irq_latch.sv
module rxg_irq_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                      flags[i] <= 1'b0;
      else if (set_vec[i])             flags[i] <= 1'b1;
      else if (clr_stb && clr_mask[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxg_cmd_slot.sv
module rxg_cmd_slot #(
  parameter int BODY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [BODY_W-1:0] body_new,
  input  logic              alt_new,
  input  logic              grant,
  output logic              valid,
  output logic [BODY_W:0]   cmd
);
  logic              valid_q;
  logic              alt_q;
  logic [BODY_W-1:0] body_q;
  logic              taken;

  assign taken = valid_q && grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      alt_q   <= 1'b0;
      body_q  <= '0;
    end else if (trig) begin
      valid_q <= 1'b1;
      body_q  <= body_new;
      // an unsent alternate flag survives the overwrite
      alt_q   <= alt_new | (alt_q && !taken);
    end else if (taken) begin
      valid_q <= 1'b0;
      alt_q   <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign cmd   = {alt_q, body_q};
endmodule

// File: rtl/rxcmd_status_gen.sv
module rxcmd_status_gen (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [rxg_pkg::LS_W-1:0]    line_state,
  input  logic [rxg_pkg::EVT_W-1:0]   rx_event,
  input  logic [rxg_pkg::NDET-1:0]    det_in,
  input  logic                        id_pullup,
  input  logic [rxg_pkg::NDET-1:0]    rise_en,
  input  logic [rxg_pkg::NDET-1:0]    fall_en,
  input  logic                        clr_stb,
  input  logic [rxg_pkg::NDET-1:0]    clr_mask,
  input  logic                        cmd_grant,
  output logic                        cmd_valid,
  output logic [rxg_pkg::BYTE_W-1:0]  cmd_byte,
  output logic [rxg_pkg::NDET-1:0]    irq_latch,
  output logic [rxg_pkg::NDET-1:0]    status_live
);
  import rxg_pkg::*;

  logic              boot_w;
  logic              ls_chg_w;
  logic              evt_chg_w;
  logic [NDET-1:0]   rise_w;
  logic [NDET-1:0]   fall_w;
  logic [BODY_W-1:0] body_w;
  logic [NDET-1:0]   set_w;
  logic [NDET-1:0]   req_edge_w;
  logic              alt_w;
  logic              trig_w;

  rxg_sampler u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ls        (line_state),
    .evt       (rx_event),
    .det       (det_in),
    .id_pullup (id_pullup),
    .boot      (boot_w),
    .ls_chg    (ls_chg_w),
    .evt_chg   (evt_chg_w),
    .rise      (rise_w),
    .fall      (fall_w),
    .body_new  (body_w),
    .det_live  (status_live)
  );

  assign set_w      = (rise_w & rise_en) | (fall_w & fall_en);
  assign req_edge_w = set_w & CMD_EDGE_MASK;
  assign alt_w      = fall_w[DET_BV] && fall_en[DET_BV];
  assign trig_w     = boot_w || ls_chg_w || evt_chg_w || (|req_edge_w) || alt_w;

  rxg_irq_latch #(.N(NDET)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_w),
    .clr_stb  (clr_stb),
    .clr_mask (clr_mask),
    .flags    (irq_latch)
  );

  rxg_cmd_slot #(.BODY_W(BODY_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig_w),
    .body_new (body_w),
    .alt_new  (alt_w),
    .grant    (cmd_grant),
    .valid    (cmd_valid),
    .cmd      (cmd_byte)
  );
endmodule

// File: rtl/rxg_chk.sv
module rxg_chk (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic [rxg_pkg::BYTE_W-1:0] cmd_byte,
  input logic                       cmd_grant,
  input logic                       trig,
  input logic                       boot,
  input logic [rxg_pkg::NDET-1:0]   irq_latch,
  input logic [rxg_pkg::NDET-1:0]   set_vec
);
  // R1
  boot_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot |=> cmd_valid);

  // R3
  trig_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cmd_valid);

  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_grant |=> cmd_valid);

  // R4
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_grant && !trig |=> $stable(cmd_byte));

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_grant && !trig |=> !cmd_valid);

  // R9
  latch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(irq_latch & ~$past(irq_latch)) |-> |$past(set_vec));
endmodule

bind rxcmd_status_gen rxg_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .cmd_grant (cmd_grant),
  .trig      (trig_w),
  .boot      (boot_w),
  .irq_latch (irq_latch),
  .set_vec   (set_w)
);

// File: tb/test_rxcmd_status_gen.sv
module test_rxcmd_status_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_state = 2'b01;
  logic [1:0] rx_event = 2'b00;
  logic [4:0] det_in = 5'b0;
  logic       id_pullup = 1'b1;
  logic [4:0] rise_en = 5'h1f;
  logic [4:0] fall_en = 5'h1e;
  logic       clr_stb = 1'b0;
  logic [4:0] clr_mask = 5'h0;
  logic       cmd_grant = 1'b0;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic [4:0] irq_latch;
  logic [4:0] status_live;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  rxcmd_status_gen i_rxcmd_status_gen (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .rx_event(rx_event),
    .det_in(det_in), .id_pullup(id_pullup), .rise_en(rise_en), .fall_en(fall_en),
    .clr_stb(clr_stb), .clr_mask(clr_mask), .cmd_grant(cmd_grant),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .irq_latch(irq_latch),
    .status_live(status_live)
  );

  typedef struct packed {
    logic [1:0] ls;
    logic [1:0] evt;
    logic [4:0] det;
    logic       v;
    logic [7:0] b;
  } vec_t;

  // det order {id, sess_end, sess_vld, vbus_vld, bvalid}
  localparam vec_t TBL [11] = '{
    '{2'b10, 2'b00, 5'b00000, 1'b1, 8'h06},  // R3 line state K
    '{2'b10, 2'b00, 5'b01000, 1'b1, 8'h02},  // R6 session end rise, level 00
    '{2'b10, 2'b00, 5'b00000, 1'b1, 8'h06},  // R6 session end fall, level 01
    '{2'b10, 2'b00, 5'b00100, 1'b1, 8'h0A},  // R2 level 10
    '{2'b10, 2'b00, 5'b00110, 1'b1, 8'h0E},  // R2 level 11
    '{2'b10, 2'b00, 5'b00111, 1'b0, 8'h00},  // R8 bvalid rise, no command
    '{2'b10, 2'b00, 5'b10111, 1'b1, 8'h4E},  // R2 id bit 6
    '{2'b10, 2'b01, 5'b10111, 1'b1, 8'h5E},  // R3 event change
    '{2'b11, 2'b01, 5'b10111, 1'b1, 8'h5F},  // R2 SE1
    '{2'b00, 2'b01, 5'b10111, 1'b1, 8'h5C},  // R2 SE0
    '{2'b00, 2'b01, 5'b10111, 1'b0, 8'h00}   // R3 no change, no command
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drain();
    @(negedge clk) cmd_grant = 1'b1;
    @(negedge clk) cmd_grant = 1'b0;
  endtask

  task automatic clear(input logic [4:0] m);
    @(negedge clk) begin clr_stb = 1'b1; clr_mask = m; end
    @(negedge clk) begin clr_stb = 1'b0; clr_mask = 5'h0; end
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 reset valid", cmd_valid, 0);
    chk(irq_latch == 5'h0, "R1 reset latch", irq_latch, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b1, "R1 boot valid", cmd_valid, 1);
    chk(cmd_byte == 8'h05, "R1 boot byte", cmd_byte, 8'h05);
    chk(irq_latch == 5'h0, "R1 boot latch", irq_latch, 0);
    drain();
    chk(cmd_valid == 1'b0, "R4 consumed", cmd_valid, 0);

    foreach (TBL[k]) begin
      @(negedge clk) begin
        line_state = TBL[k].ls; rx_event = TBL[k].evt; det_in = TBL[k].det;
      end
      @(negedge clk);
      chk(cmd_valid == TBL[k].v, "R3/R6 table valid", cmd_valid, TBL[k].v);
      if (TBL[k].v) chk(cmd_byte == TBL[k].b, "R2 table byte", cmd_byte, TBL[k].b);
      drain();
    end
    chk(irq_latch == 5'h1f, "R9 latches after table", irq_latch, 5'h1f);
    chk(status_live == 5'b10111, "R10 live status", status_live, 5'b10111);
    clear(5'h1f);
    chk(irq_latch == 5'h0, "R9 cleared", irq_latch, 0);

    // R5 overwrite without grant
    @(negedge clk) line_state = 2'b01;
    @(negedge clk) chk(cmd_byte == 8'h5D, "R5 first", cmd_byte, 8'h5D);
    line_state = 2'b10;
    @(negedge clk) chk(cmd_byte == 8'h5E && cmd_valid, "R5 overwrite", cmd_byte, 8'h5E);
    drain();
    chk(cmd_valid == 1'b0, "R5 no stale copy", cmd_valid, 0);

    // R5 change at the grant edge
    @(negedge clk) line_state = 2'b11;
    @(negedge clk) begin cmd_grant = 1'b1; line_state = 2'b01; end
    @(negedge clk) begin
      cmd_grant = 1'b0;
      chk(cmd_valid == 1'b1 && cmd_byte == 8'h5D, "R5 grant plus change", cmd_byte, 8'h5D);
    end
    drain();

    // R6 disabled edges
    @(negedge clk) begin rise_en = 5'h0; fall_en = 5'h0; det_in = 5'b10011; end
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R6 disabled no command", cmd_valid, 0);
    chk(irq_latch == 5'h0, "R6 disabled no latch", irq_latch, 0);
    chk(status_live == 5'b10011, "R10 live follows", status_live, 5'b10011);
    rise_en = 5'h1f; fall_en = 5'h1e;

    // R7 id while pull-up off
    @(negedge clk) begin id_pullup = 1'b0; det_in = 5'b00011; end
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R7 id ignored", cmd_valid, 0);
    chk(irq_latch == 5'h0, "R7 no id latch", irq_latch, 0);
    line_state = 2'b00;
    @(negedge clk) chk(cmd_byte == 8'h5C, "R7 id bit held", cmd_byte, 8'h5C);
    drain();

    // R8 alternate flag
    @(negedge clk) begin id_pullup = 1'b1; fall_en = 5'h1f; det_in = 5'b00010; end
    @(negedge clk) chk(cmd_valid && cmd_byte == 8'h9C, "R8 alt set", cmd_byte, 8'h9C);
    line_state = 2'b01;
    @(negedge clk) chk(cmd_byte == 8'h9D, "R8 alt kept", cmd_byte, 8'h9D);
    drain();
    @(negedge clk) line_state = 2'b10;
    @(negedge clk) chk(cmd_byte == 8'h1E, "R8 alt cleared", cmd_byte, 8'h1E);
    drain();
    chk(irq_latch == 5'h01, "R9 bvalid latch", irq_latch, 5'h01);

    // R9 set wins over clear
    @(negedge clk) begin det_in = 5'b00000; clr_stb = 1'b1; clr_mask = 5'h02; end
    @(negedge clk) begin clr_stb = 1'b0; clr_mask = 5'h0; end
    chk(irq_latch == 5'h03, "R9 set wins", irq_latch, 5'h03);
    drain();
    clear(5'h03);
    chk(irq_latch == 5'h0, "R9 final clear", irq_latch, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule